// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital heart of a 12-bit successive-approximation converter that sits on a shared parallel bus. A host writes an 8-bit control byte with a write strobe while chip select is low. The byte picks the power and clock mode, the way the sample window is timed, single-ended or pseudo-differential input, unipolar or bipolar coding, and the input channel. The block then times the acquisition window and marks the sampling instant. It runs a bit-serial search against a one-bit comparator input. When the result is ready it pulls an active-low interrupt and presents the coded result on a read bus with an output enable.

Every sequencing step advances on a conversion tick. In external-clock mode a tick is a falling edge of the conversion clock input. In internal-clock mode a tick is produced every `INT_DIV` system clocks, and the divider restarts at each accepted write. The analog front end is not part of the block: it only sees the trial code on `dac_code` and answers on `cmp_in`.

Top module: `adc_conv_seq`

## Requirements
- R1: A control byte is taken from `data_in` on the rising edge of `wr_n` while `cs_n` is low. The bit layout is as follows:
  - bits [7:6] are the power code;
  - bit 5 set requests an externally bounded acquisition;
  - bit 4 set selects single-ended input;
  - bit 3 set selects unipolar coding;
  - bits [2:0] are the channel address.

  `mux_pos` equals the address. `mux_neg` is 7 (the common return) in single-ended mode and the address with bit 0 inverted in pseudo-differential mode.
- R2: Power code 00 gives `pwr_mode`=00 (shutdown) and 01 gives `pwr_mode`=01 (standby). Either code starts no conversion and leaves `clk_int` unchanged. Codes 10 and 11 give `pwr_mode`=10 (running), set `clk_int` to bit 6 and wake the block.
- R3: With bit 5 clear, `hold` rises on the 4th conversion tick after the write and not earlier.
- R4: A write with bit 5 set leaves acquisition open, with no `hold`, however many ticks arrive. A following write with bit 5 clear and bits [4:0] unchanged raises `hold` at once. A power-down code carried by that second write takes effect when its conversion ends.
- R5: `irq_n` goes low on the 13th tick after `hold` rises, not on the 12th, and `hold` falls at the same time.
- R6: The search tries bits from MSB to LSB on `dac_code`. A bit is kept when `cmp_in` is 1, meaning the trial does not exceed the input. The raw result is therefore the largest code the comparator accepts.
- R7: In unipolar mode the result is the raw code. In bipolar mode it is two's complement, which is the raw code with its MSB inverted.
- R8: `irq_n` returns high on the falling edge of `rd_n` with `cs_n` low, or on any accepted write.
- R9: A write during acquisition or conversion abandons that work. The block restarts from the new byte, and no interrupt is raised for the abandoned sample.
- R10: After reset, `irq_n`=1, `pwr_mode`=10, `clk_int`=0, `hold`=0 and `cfg_err`=0.
- R11: While `cs_n` is high, `rd_oe` and `irq_oe` are 0. Writes, reads and external conversion-clock edges are ignored.
- R12: An address at or above `NUM_CH` in single-ended mode, or at or above twice the number of whole pairs in pseudo-differential mode, sets `cfg_err`. Such a write abandons current work, starts nothing and leaves the channel selection unchanged. A valid write clears `cfg_err`.
- R13: In internal-clock mode a tick occurs every `INT_DIV` system clocks, counted from the write. `irq_n` therefore falls exactly 17×`INT_DIV` clocks after the write is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; the byte is taken on its rising edge |
| rd_n | input | 1 | Active-low read strobe |
| data_in | input | 8 | Control byte from the bus |
| conv_clk | input | 1 | External conversion clock; a falling edge is one tick |
| cmp_in | input | 1 | Comparator answer: 1 means the trial does not exceed the input |
| rd_data | output | 12 | Coded result |
| rd_oe | output | 1 | Drive enable for `rd_data` |
| irq_n | output | 1 | Active-low result-ready interrupt |
| irq_oe | output | 1 | Drive enable for `irq_n` |
| dac_code | output | 12 | Trial code for the comparator |
| hold | output | 1 | High from the sampling instant to the end of conversion |
| mux_pos | output | 3 | Positive input channel |
| mux_neg | output | 3 | Negative input channel, 7 = common return |
| pwr_mode | output | 2 | 00 shutdown, 01 standby, 10 running |
| clk_int | output | 1 | 1 when internal-clock mode is selected |
| cfg_err | output | 1 | Last write carried an invalid address |

## Verification
A wrong sequencer state shows first on `hold` and `irq_n`, which the bench counts in exact ticks. If the acquisition counter or the conversion counter is off by one, the edge lands one tick early or late and is caught at that tick. A fault in the search or in the result coding shows on the next read, as a value that differs from the bench's comparator model. A wrong abort or ignore decision shows as an interrupt where none is allowed, or as a stale channel or result.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int          BYTE_W  = 8;
    localparam logic [2:0]  COM_SEL = 3'd7;

    typedef enum logic [1:0] {
        PWR_OFF  = 2'b00,
        PWR_STBY = 2'b01,
        PWR_RUN  = 2'b10
    } pwr_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ACQ_INT,
        SQ_ACQ_EXT,
        SQ_CONV
    } seq_e;

    typedef struct packed {
        logic [1:0] pd;
        logic       acq_ext;
        logic       single;
        logic       unipolar;
        logic [2:0] addr;
    } ctrl_t;

    function automatic logic addr_ok(input ctrl_t c, input int unsigned n_ch);
        int unsigned lim;
        lim = c.single ? n_ch : (n_ch / 2) * 2;
        return int'(c.addr) < int'(lim);
    endfunction

    function automatic logic [2:0] neg_sel(input ctrl_t c);
        return c.single ? COM_SEL : (c.addr ^ 3'd1);
    endfunction

    function automatic logic same_setup(input ctrl_t a, input ctrl_t b);
        return (a.single == b.single) && (a.unipolar == b.unipolar) && (a.addr == b.addr);
    endfunction

endpackage

// File: rtl/adc_bus_front.sv
module adc_bus_front (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    input  logic conv_clk,
    output logic wr_go,
    output logic rd_go,
    output logic ext_fall
);
    logic wr_q, rd_q, cc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b1;
            rd_q <= 1'b1;
            cc_q <= 1'b0;
        end else begin
            wr_q <= wr_n;
            rd_q <= rd_n;
            cc_q <= conv_clk;
        end
    end

    assign wr_go    = ~cs_n & wr_n & ~wr_q;
    assign rd_go    = ~cs_n & ~rd_n & rd_q;
    assign ext_fall = ~cs_n & ~conv_clk & cc_q;
endmodule

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
    parameter int INT_DIV = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic use_int,
    input  logic ext_fall,
    output logic tick
);
    localparam int               CNT_W   = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(INT_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             int_tick;

    assign int_tick = (cnt_q == CNT_TOP);

    always_ff @(posedge clk) begin
        if (rst || restart)  cnt_q <= '0;
        else if (int_tick)   cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    assign tick = use_int ? int_tick : ext_fall;

    AST_DIV_GAP: assert property (@(posedge clk) disable iff (rst)
        (use_int && int_tick && !restart) |=> !int_tick); // R13
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
    parameter int RES = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           start,
    input  logic           step,
    input  logic           cmp_in,
    output logic [RES-1:0] trial,
    output logic [RES-1:0] final_code,
    output logic           last
);
    localparam logic [RES-1:0] TOP_BIT = {1'b1, {(RES-1){1'b0}}};

    logic [RES-1:0] acc_q, mask_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q  <= '0;
            mask_q <= '0;
        end else if (start) begin
            acc_q  <= '0;
            mask_q <= TOP_BIT;
        end else if (step && (mask_q != '0)) begin
            if (cmp_in) acc_q <= acc_q | mask_q;
            mask_q <= mask_q >> 1;
        end
    end

    assign trial      = acc_q | mask_q;
    assign final_code = cmp_in ? trial : acc_q;
    assign last       = step & mask_q[0];

    AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mask_q)); // R6
    AST_KEEP_BIT: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && !start && (mask_q != '0) && cmp_in) |=> ((acc_q & $past(mask_q)) != '0)); // R6
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int RES       = 12,
    parameter int NUM_CH    = 6,
    parameter int INT_DIV   = 6,
    parameter int ACQ_TICKS = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cs_n,
    input  logic           wr_n,
    input  logic           rd_n,
    input  logic [7:0]     data_in,
    input  logic           conv_clk,
    input  logic           cmp_in,
    output logic [RES-1:0] rd_data,
    output logic           rd_oe,
    output logic           irq_n,
    output logic           irq_oe,
    output logic [RES-1:0] dac_code,
    output logic           hold,
    output logic [2:0]     mux_pos,
    output logic [2:0]     mux_neg,
    output logic [1:0]     pwr_mode,
    output logic           clk_int,
    output logic           cfg_err
);
    localparam int               ACQ_W   = (ACQ_TICKS > 1) ? $clog2(ACQ_TICKS) : 1;
    localparam logic [ACQ_W-1:0] ACQ_TOP = ACQ_W'(ACQ_TICKS - 1);
    localparam ctrl_t            CFG_RST = '{pd: 2'b10, acq_ext: 1'b0, single: 1'b1,
                                             unipolar: 1'b1, addr: 3'd0};

    logic wr_go, rd_go, ext_fall, tick;
    logic sar_start, sar_step, sar_last;
    logic [RES-1:0] sar_trial, sar_final, coded;

    ctrl_t            cfg_q, wr_byte;
    seq_e             state_q;
    pwr_e             pwr_q, pend_q;
    logic [ACQ_W-1:0] acq_cnt_q;
    logic             setup_due_q, irq_q, clk_int_q, err_q;
    logic [RES-1:0]   result_q;

    assign wr_byte = ctrl_t'(data_in[BYTE_W-1:0]);

    adc_bus_front u_front (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .rd_n     (rd_n),
        .conv_clk (conv_clk),
        .wr_go    (wr_go),
        .rd_go    (rd_go),
        .ext_fall (ext_fall)
    );

    adc_tick_gen #(.INT_DIV(INT_DIV)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .restart  (wr_go),
        .use_int  (clk_int_q),
        .ext_fall (ext_fall),
        .tick     (tick)
    );

    assign sar_start = (state_q == SQ_CONV) && tick && setup_due_q && !wr_go;
    assign sar_step  = (state_q == SQ_CONV) && tick && !setup_due_q && !wr_go;

    adc_sar_core #(.RES(RES)) u_sar (
        .clk        (clk),
        .rst        (rst),
        .clear      (wr_go),
        .start      (sar_start),
        .step       (sar_step),
        .cmp_in     (cmp_in),
        .trial      (sar_trial),
        .final_code (sar_final),
        .last       (sar_last)
    );

    assign coded = cfg_q.unipolar ? sar_final : {~sar_final[RES-1], sar_final[RES-2:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q       <= CFG_RST;
            state_q     <= SQ_IDLE;
            pwr_q       <= PWR_RUN;
            pend_q      <= PWR_RUN;
            acq_cnt_q   <= '0;
            setup_due_q <= 1'b0;
            irq_q       <= 1'b0;
            clk_int_q   <= 1'b0;
            err_q       <= 1'b0;
            result_q    <= '0;
        end else if (wr_go) begin
            irq_q <= 1'b0;
            if (!addr_ok(wr_byte, NUM_CH)) begin
                err_q   <= 1'b1;
                state_q <= SQ_IDLE;
            end else begin
                err_q <= 1'b0;
                if ((state_q == SQ_ACQ_EXT) && !wr_byte.acq_ext && same_setup(wr_byte, cfg_q)) begin
                    cfg_q       <= wr_byte;
                    state_q     <= SQ_CONV;
                    setup_due_q <= 1'b1;
                    if (wr_byte.pd[1]) begin
                        clk_int_q <= wr_byte.pd[0];
                        pend_q    <= PWR_RUN;
                    end else begin
                        pend_q    <= pwr_e'(wr_byte.pd);
                    end
                end else begin
                    cfg_q  <= wr_byte;
                    pend_q <= PWR_RUN;
                    if (!wr_byte.pd[1]) begin
                        pwr_q   <= pwr_e'(wr_byte.pd);
                        state_q <= SQ_IDLE;
                    end else begin
                        pwr_q     <= PWR_RUN;
                        clk_int_q <= wr_byte.pd[0];
                        acq_cnt_q <= '0;
                        state_q   <= wr_byte.acq_ext ? SQ_ACQ_EXT : SQ_ACQ_INT;
                    end
                end
            end
        end else begin
            if (rd_go) irq_q <= 1'b0;
            if (tick) begin
                unique case (state_q)
                    SQ_ACQ_INT: begin
                        if (acq_cnt_q == ACQ_TOP) begin
                            state_q     <= SQ_CONV;
                            setup_due_q <= 1'b1;
                        end else begin
                            acq_cnt_q <= acq_cnt_q + 1'b1;
                        end
                    end
                    SQ_CONV: begin
                        if (setup_due_q) begin
                            setup_due_q <= 1'b0;
                        end else if (sar_last) begin
                            result_q <= coded;
                            irq_q    <= 1'b1;
                            state_q  <= SQ_IDLE;
                            pwr_q    <= pend_q;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_data  = result_q;
    assign rd_oe    = ~cs_n & ~rd_n;
    assign irq_n    = ~irq_q;
    assign irq_oe   = ~cs_n;
    assign dac_code = sar_trial;
    assign hold     = (state_q == SQ_CONV);
    assign mux_pos  = cfg_q.addr;
    assign mux_neg  = neg_sel(cfg_q);
    assign pwr_mode = pwr_q;
    assign clk_int  = clk_int_q;
    assign cfg_err  = err_q;

    AST_CS_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> $stable(cfg_q)); // R11
    AST_CONV_ONLY_RUN: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_CONV) |-> (pwr_q == PWR_RUN)); // R2
    AST_IRQ_FROM_CONV: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> ($past(state_q) == SQ_CONV)); // R5
    AST_BAD_ADDR_IDLE: assert property (@(posedge clk) disable iff (rst)
        (wr_go && !addr_ok(wr_byte, NUM_CH)) |=> (state_q == SQ_IDLE && err_q && !irq_q)); // R12
    AST_WR_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        wr_go |=> !irq_q); // R8
    AST_HOLD_ON_LAST_ACQ: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_ACQ_INT && tick && acq_cnt_q == ACQ_TOP && !wr_go) |=> (state_q == SQ_CONV)); // R3
endmodule

// File: tb/sim_adc_conv_seq.sv
`timescale 1ns/1ps
module sim_adc_conv_seq;
    localparam int RES = 12;
    localparam int NCH = 6;
    localparam int DIV = 6;

    logic clk = 1'b0;
    logic rst, cs_n, wr_n, rd_n, conv_clk, cmp_in;
    logic [7:0] data_in;
    logic [RES-1:0] rd_data, dac_code, vin;
    logic rd_oe, irq_n, irq_oe, hold, clk_int, cfg_err;
    logic [2:0] mux_pos, mux_neg;
    logic [1:0] pwr_mode;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    assign cmp_in = (dac_code <= vin);

    adc_conv_seq #(.RES(RES), .NUM_CH(NCH), .INT_DIV(DIV), .ACQ_TICKS(4)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .data_in(data_in), .conv_clk(conv_clk), .cmp_in(cmp_in),
        .rd_data(rd_data), .rd_oe(rd_oe), .irq_n(irq_n), .irq_oe(irq_oe),
        .dac_code(dac_code), .hold(hold), .mux_pos(mux_pos), .mux_neg(mux_neg),
        .pwr_mode(pwr_mode), .clk_int(clk_int), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(input logic [1:0] pd, input logic ext,
                                      input logic sgl, input logic uni, input logic [2:0] a);
        return {pd, ext, sgl, uni, a};
    endfunction

    function automatic logic [RES-1:0] exp_code(input logic [RES-1:0] v, input logic uni);
        return uni ? v : (v ^ 12'h800);
    endfunction

    task automatic wr_byte(input logic [7:0] b);
        @(posedge clk); #1 cs_n = 1'b0; data_in = b; wr_n = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1 wr_n = 1'b1;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 conv_clk = 1'b1;
            @(posedge clk); #1 conv_clk = 1'b0;
        end
        @(posedge clk); @(negedge clk);
    endtask

    task automatic rd_result(output logic [RES-1:0] d, output logic oe);
        @(posedge clk); #1 rd_n = 1'b0;
        @(negedge clk); d = rd_data; oe = rd_oe;
        @(posedge clk); #1 rd_n = 1'b1;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [RES-1:0] d;
        logic oe;
        int m;
        void'($urandom(32'd2718));
        rst = 1'b1; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
        conv_clk = 1'b0; data_in = '0; vin = '0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk("R10 irq_n", irq_n, 1);
        chk("R10 pwr_mode", pwr_mode, 2);
        chk("R10 clk_int", clk_int, 0);
        chk("R10 hold", hold, 0);
        chk("R10 cfg_err", cfg_err, 0);
        // R11 outputs released while deselected
        chk("R11 irq_oe cs high", irq_oe, 0);
        chk("R11 rd_oe cs high", rd_oe, 0);
        #1 cs_n = 1'b0;
        @(negedge clk);
        chk("R11 irq_oe cs low", irq_oe, 1);

        // R1 R3 R5 R6 internal acquisition, single-ended unipolar
        vin = 12'hA5C;
        wr_byte(mk(2'b10, 1'b0, 1'b1, 1'b1, 3'd3));
        chk("R1 mux_pos single", mux_pos, 3);
        chk("R1 mux_neg single", mux_neg, 7);
        edges(3);
        chk("R3 no hold after 3 ticks", hold, 0);
        edges(1);
        chk("R3 hold on 4th tick", hold, 1);
        edges(12);
        chk("R5 irq_n high after 12", irq_n, 1);
        edges(1);
        chk("R5 irq_n low after 13", irq_n, 0);
        chk("R5 hold released", hold, 0);
        rd_result(d, oe);
        chk("R6 result", d, 12'hA5C);
        chk("R11 rd_oe during read", oe, 1);
        chk("R8 irq released by read", irq_n, 1);

        // R1 pseudo-differential pair decode
        vin = 12'h001;
        wr_byte(mk(2'b10, 1'b0, 1'b0, 1'b1, 3'd3));
        chk("R1 mux_pos diff", mux_pos, 3);
        chk("R1 mux_neg diff", mux_neg, 2);
        edges(17);
        rd_result(d, oe);
        chk("R6 small code", d, 12'h001);

        // R7 bipolar coding
        vin = 12'h123;
        wr_byte(mk(2'b10, 1'b0, 1'b1, 1'b0, 3'd0));
        edges(17);
        rd_result(d, oe);
        chk("R7 bipolar low half", d, 12'h923);
        vin = 12'hF00;
        wr_byte(mk(2'b10, 1'b0, 1'b1, 1'b0, 3'd1));
        edges(17);
        rd_result(d, oe);
        chk("R7 bipolar high half", d, 12'h700);

        // R4 external acquisition with pending shutdown
        vin = 12'h3C1;
        wr_byte(mk(2'b10, 1'b1, 1'b1, 1'b1, 3'd2));
        edges(25);
        chk("R4 acquisition stays open", hold, 0);
        chk("R4 no irq while open", irq_n, 1);
        wr_byte(mk(2'b00, 1'b0, 1'b1, 1'b1, 3'd2));
        chk("R4 hold at second write", hold, 1);
        chk("R4 still running", pwr_mode, 2);
        edges(12);
        chk("R5 ext irq_n high after 12", irq_n, 1);
        edges(1);
        chk("R5 ext irq_n low after 13", irq_n, 0);
        chk("R4 pending shutdown applied", pwr_mode, 0);
        rd_result(d, oe);
        chk("R4 ext result", d, 12'h3C1);

        // R2 standby: no conversion
        wr_byte(mk(2'b01, 1'b0, 1'b1, 1'b1, 3'd1));
        chk("R2 standby code", pwr_mode, 1);
        chk("R2 clock mode kept", clk_int, 0);
        edges(20);
        chk("R2 standby no hold", hold, 0);
        chk("R2 standby no irq", irq_n, 1);

        // R13 R2 internal clock wake-up and timing
        vin = 12'h7FF;
        wr_byte(mk(2'b11, 1'b0, 1'b1, 1'b1, 3'd4));
        chk("R2 wake running", pwr_mode, 2);
        chk("R2 internal clock", clk_int, 1);
        m = 0;
        while (irq_n && m < 1000) begin
            @(negedge clk);
            m++;
        end
        chk("R13 internal clock cycles", m, 17 * DIV);
        rd_result(d, oe);
        chk("R13 internal clock result", d, 12'h7FF);
        wr_byte(mk(2'b00, 1'b0, 1'b1, 1'b1, 3'd4));
        chk("R2 shutdown code", pwr_mode, 0);
        chk("R2 shutdown keeps internal clock", clk_int, 1);

        // R9 abort
        vin = 12'h111;
        wr_byte(mk(2'b10, 1'b0, 1'b1, 1'b1, 3'd0));
        chk("R2 external clock again", clk_int, 0);
        edges(10);
        vin = 12'h8AB;
        wr_byte(mk(2'b10, 1'b0, 1'b1, 1'b1, 3'd1));
        chk("R9 hold dropped by write", hold, 0);
        edges(16);
        chk("R9 no irq for abandoned sample", irq_n, 1);
        edges(1);
        chk("R9 irq for new sample", irq_n, 0);
        // R8 new write releases irq
        wr_byte(mk(2'b10, 1'b0, 1'b1, 1'b1, 3'd1));
        chk("R8 irq released by write", irq_n, 1);
        edges(17);
        rd_result(d, oe);
        chk("R9 new result", d, 12'h8AB);

        // R12 invalid address
        wr_byte(mk(2'b10, 1'b0, 1'b1, 1'b1, 3'd6));
        chk("R12 err single", cfg_err, 1);
        chk("R12 channel kept", mux_pos, 1);
        edges(20);
        chk("R12 no hold", hold, 0);
        chk("R12 no irq", irq_n, 1);
        wr_byte(mk(2'b10, 1'b0, 1'b0, 1'b1, 3'd7));
        chk("R12 err diff", cfg_err, 1);
        vin = 12'h456;
        wr_byte(mk(2'b10, 1'b0, 1'b1, 1'b1, 3'd5));
        chk("R12 err cleared", cfg_err, 0);
        edges(17);
        rd_result(d, oe);
        chk("R12 valid after error", d, 12'h456);

        // R11 write ignored while deselected
        @(posedge clk); #1 cs_n = 1'b1; data_in = mk(2'b10, 1'b0, 1'b1, 1'b1, 3'd2); wr_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 wr_n = 1'b1;
        repeat (2) @(posedge clk);
        #1 cs_n = 1'b0;
        edges(5);
        chk("R11 write ignored channel", mux_pos, 5);
        chk("R11 write ignored hold", hold, 0);
        // R11 clock edges ignored while deselected
        vin = 12'hC3A;
        wr_byte(mk(2'b10, 1'b0, 1'b1, 1'b1, 3'd2));
        edges(4);
        #1 cs_n = 1'b1;
        edges(20);
        #1 cs_n = 1'b0;
        @(negedge clk);
        chk("R11 edges ignored irq", irq_n, 1);
        edges(12);
        chk("R11 irq after 12 selected", irq_n, 1);
        edges(1);
        chk("R11 irq after 13 selected", irq_n, 0);
        rd_result(d, oe);
        chk("R11 result", d, 12'hC3A);

        // R6 R7 R4 random conversions
        for (int k = 0; k < 40; k++) begin
            logic sgl, uni, ext;
            logic [2:0] a;
            sgl = 1'($urandom);
            uni = 1'($urandom);
            ext = 1'($urandom);
            a   = 3'($urandom_range(0, NCH - 1));
            vin = RES'($urandom);
            if (ext) begin
                wr_byte(mk(2'b10, 1'b1, sgl, uni, a));
                edges($urandom_range(1, 8));
                wr_byte(mk(2'b10, 1'b0, sgl, uni, a));
                edges(12);
            end else begin
                wr_byte(mk(2'b10, 1'b0, sgl, uni, a));
                edges(16);
            end
            chk("R5 random irq early", irq_n, 1);
            edges(1);
            chk("R5 random irq", irq_n, 0);
            rd_result(d, oe);
            chk("R6 R7 random result", d, exp_code(vin, uni));
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule